// File: doc/BRIEF.md
# Read Tag Ordering Tracker

This block sits beside a read request/response path and keeps count of the read transactions in flight. Each request carries an ID of `ID_W` bits, which gives `2^ID_W` separate tags. The block hands every accepted request a per-ID sequence number on `req_seq`, and the responder sends that number back on `rsp_seq`. From these numbers the block checks that responses sharing an ID come back in the order the requests were issued. Responses with different IDs may overtake one another freely. Read traffic is never ordered against write traffic, and the block has no write ports.

The request side is a valid/ready interface. The master holds `req_valid` and `req_id` until `req_ready` is high at a rising edge. `req_ready` is combinational and falls when either of two limits is reached: the global in-flight total (`MAX_OUT`) or the per-ID queue depth (`ID_DEPTH`). The master sees this as back-pressure and has to wait for a retirement. The response side is observed only: a beat counts when `rsp_valid` and `rsp_ready` are both high at a rising edge. A transaction retires on its beat flagged last. An out-of-order response or an unexpected response raises a one-cycle error pulse and leaves all state untouched.

Top module: `rd_tag_tracker`

## Requirements
- R1: `req_ready` is high in the same cycle, combinationally, when the in-flight total is below `MAX_OUT` (default 6) and the pending count of `req_id` is below `ID_DEPTH` (default 4). A request is accepted at a rising edge where `req_valid` and `req_ready` are both high.
- R2: `ID_W` (default 2) bits give `2^ID_W` independent tags. Responses for different IDs may return in any order without raising any error.
- R3: The in-flight total never exceeds `MAX_OUT`. With `MAX_OUT` transactions in flight, `req_ready` stays low for every ID, and a held `req_valid` is not accepted, until a retirement occurs.
- R4: No ID has more than `ID_DEPTH` pending requests. When one ID is full, `req_ready` is low for that ID and stays high for other IDs.
- R5: `req_seq` shows the sequence number that the present `req_id` would receive. It starts at 0 after reset and advances by one, modulo `2^($clog2(ID_DEPTH)+1)` (8 by default), for each accepted request of that ID. A response whose `rsp_seq` differs from the oldest pending number of its ID raises `order_err` for one cycle, in the cycle after the handshake, and changes no state.
- R6: A response handshake on an ID with no pending request raises `unexp_err` for one cycle, in the cycle after the handshake, and changes no state. A request of the same ID accepted in the same cycle does not count as pending. `rsp_valid` without `rsp_ready` is ignored.
- R7: Only a matching beat with `rsp_last` = 1 retires a transaction. Matching beats with `rsp_last` = 0 free no slot and leave `outstanding` unchanged.
- R8: `outstanding` reports the in-flight total one cycle after the handshakes. When an accept and a retirement fall in the same cycle, it is unchanged.
- R9: After reset, `outstanding` = 0, both error outputs are 0, every sequence number is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Issue permit (combinational) |
| req_id | input | ID_W | Request ID |
| req_seq | output | $clog2(ID_DEPTH)+1 | Sequence number for this request |
| rsp_valid | input | 1 | Response beat present |
| rsp_ready | input | 1 | Response beat taken by master |
| rsp_id | input | ID_W | Response ID |
| rsp_seq | input | $clog2(ID_DEPTH)+1 | Sequence number echoed by responder |
| rsp_last | input | 1 | Final beat of the transaction |
| outstanding | output | $clog2(MAX_OUT+1) | In-flight total |
| order_err | output | 1 | Same-ID ordering violation pulse |
| unexp_err | output | 1 | Response with nothing pending pulse |

## Verification
The hardest state to reach is the global limit with no single ID full. Only then does `req_ready` fall purely because of the total. The bench reaches it by spreading six requests over two IDs, three each, and then holds a request on a third ID against the low permit. It also drives an accept and a response for the same empty ID in one cycle. This checks that the response is judged against the state before that edge.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [2:0] {
    VD_IDLE,
    VD_BEAT,
    VD_RETIRE,
    VD_ORDER,
    VD_UNEXP
  } rsp_verdict_e;
endpackage

// File: rtl/rtt_id_slot.sv
module rtt_id_slot #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  parameter int SEQ_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             retire,
  output logic [CNT_W-1:0] cnt,
  output logic [SEQ_W-1:0] head_seq,
  output logic [SEQ_W-1:0] tail_seq
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      head_seq <= '0;
      tail_seq <= '0;
    end else begin
      if (issue)  tail_seq <= tail_seq + 1'b1;
      if (retire) head_seq <= head_seq + 1'b1;
      case ({issue, retire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !retire) |-> (cnt < DEPTH_C));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (cnt != '0));
endmodule

// File: rtl/rtt_rsp_judge.sv
module rtt_rsp_judge #(
  parameter int CNT_W = 3,
  parameter int SEQ_W = 3
) (
  input  logic                     fire,
  input  logic                     last,
  input  logic [SEQ_W-1:0]         seq,
  input  logic [CNT_W-1:0]         pend_cnt,
  input  logic [SEQ_W-1:0]         head_seq,
  output rtt_pkg::rsp_verdict_e    verdict
);
  always_comb begin
    if (!fire)                 verdict = rtt_pkg::VD_IDLE;
    else if (pend_cnt == '0)   verdict = rtt_pkg::VD_UNEXP;
    else if (seq != head_seq)  verdict = rtt_pkg::VD_ORDER;
    else if (last)             verdict = rtt_pkg::VD_RETIRE;
    else                       verdict = rtt_pkg::VD_BEAT;
  end
endmodule

// File: rtl/rtt_total_count.sv
module rtt_total_count #(
  parameter int MAX_OUT = 6,
  parameter int TOT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [TOT_W-1:0] total
);
  localparam logic [TOT_W-1:0] MAX_C = TOT_W'(MAX_OUT);

  always_ff @(posedge clk) begin
    if (!rst_n) total <= '0;
    else begin
      case ({inc, dec})
        2'b10:   total <= total + 1'b1;
        2'b01:   total <= total - 1'b1;
        default: total <= total;
      endcase
    end
  end

  assert_total_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    total <= MAX_C);
  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == dec) |=> $stable(total));
endmodule

// File: rtl/rd_tag_tracker.sv
module rd_tag_tracker #(
  parameter int ID_W     = 2,
  parameter int ID_DEPTH = 4,
  parameter int MAX_OUT  = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ID_W-1:0]               req_id,
  output logic [$clog2(ID_DEPTH):0]     req_seq,
  input  logic                          rsp_valid,
  input  logic                          rsp_ready,
  input  logic [ID_W-1:0]               rsp_id,
  input  logic [$clog2(ID_DEPTH):0]     rsp_seq,
  input  logic                          rsp_last,
  output logic [$clog2(MAX_OUT+1)-1:0]  outstanding,
  output logic                          order_err,
  output logic                          unexp_err
);
  localparam int NUM_ID = 1 << ID_W;
  localparam int SEQ_W  = $clog2(ID_DEPTH) + 1;
  localparam int CNT_W  = $clog2(ID_DEPTH + 1);
  localparam int TOT_W  = $clog2(MAX_OUT + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(ID_DEPTH);
  localparam logic [TOT_W-1:0] MAX_C   = TOT_W'(MAX_OUT);

  logic [CNT_W-1:0] slot_cnt  [NUM_ID];
  logic [SEQ_W-1:0] slot_head [NUM_ID];
  logic [SEQ_W-1:0] slot_tail [NUM_ID];
  logic issue_fire, rsp_fire, retire_fire;
  rtt_pkg::rsp_verdict_e verdict;

  assign req_ready  = (outstanding < MAX_C) && (slot_cnt[req_id] < DEPTH_C);
  assign req_seq    = slot_tail[req_id];
  assign issue_fire = req_valid && req_ready;
  assign rsp_fire   = rsp_valid && rsp_ready;
  assign retire_fire = (verdict == rtt_pkg::VD_RETIRE);

  for (genvar g = 0; g < NUM_ID; g++) begin : g_slot
    rtt_id_slot #(.DEPTH(ID_DEPTH), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (issue_fire && (req_id == ID_W'(g))),
      .retire   (retire_fire && (rsp_id == ID_W'(g))),
      .cnt      (slot_cnt[g]),
      .head_seq (slot_head[g]),
      .tail_seq (slot_tail[g])
    );
  end

  rtt_rsp_judge #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_judge (
    .fire     (rsp_fire),
    .last     (rsp_last),
    .seq      (rsp_seq),
    .pend_cnt (slot_cnt[rsp_id]),
    .head_seq (slot_head[rsp_id]),
    .verdict  (verdict)
  );

  rtt_total_count #(.MAX_OUT(MAX_OUT), .TOT_W(TOT_W)) u_total (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (issue_fire),
    .dec   (retire_fire),
    .total (outstanding)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      order_err <= 1'b0;
      unexp_err <= 1'b0;
    end else begin
      order_err <= (verdict == rtt_pkg::VD_ORDER);
      unexp_err <= (verdict == rtt_pkg::VD_UNEXP);
    end
  end

  assert_order_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    order_err |-> $past(rsp_valid && rsp_ready));
  assert_unexp_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unexp_err |-> $past(rsp_valid && rsp_ready));
  assert_err_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(order_err && unexp_err));
  assert_nonlast_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && !rsp_last && !issue_fire) |=> $stable(outstanding));
  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (outstanding == MAX_C && !retire_fire) |=> !(req_valid && req_ready) || (outstanding < MAX_C));
endmodule

// File: tb/tb_rd_tag_tracker.sv
module tb_rd_tag_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_valid = 1'b0, rsp_ready = 1'b0, rsp_last = 1'b0;
  logic [1:0] req_id = '0, rsp_id = '0;
  logic [2:0] rsp_seq = '0;
  logic req_ready, order_err, unexp_err;
  logic [2:0] req_seq, outstanding;

  int n_chk = 0, n_fail = 0;
  int exp_tot = 0;
  int exp_head [4] = '{0, 0, 0, 0};
  int exp_tail [4] = '{0, 0, 0, 0};

  always #10 clk = ~clk;

  rd_tag_tracker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_seq(req_seq), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_id(rsp_id), .rsp_seq(rsp_seq), .rsp_last(rsp_last),
    .outstanding(outstanding), .order_err(order_err), .unexp_err(unexp_err)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue_one(int id);
    @(negedge clk);
    req_valid = 1'b1; req_id = 2'(id);
    #1;
    chk(req_ready == 1'b1, "R1 permit", int'(req_ready), 1);
    chk(int'(req_seq) == exp_tail[id], "R5 seq", int'(req_seq), exp_tail[id]);
    @(negedge clk);
    req_valid = 1'b0;
    exp_tail[id] = (exp_tail[id] + 1) % 8;
    exp_tot++;
    chk(int'(outstanding) == exp_tot, "R8 count after issue", int'(outstanding), exp_tot);
  endtask

  task automatic respond(int id, int seq, bit last, bit e_ord, bit e_unx, string req);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_ready = 1'b1; rsp_id = 2'(id); rsp_seq = 3'(seq); rsp_last = last;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_ready = 1'b0; rsp_last = 1'b0;
    chk(order_err == e_ord, {req, " order_err"}, int'(order_err), int'(e_ord));
    chk(unexp_err == e_unx, {req, " unexp_err"}, int'(unexp_err), int'(e_unx));
    if (!e_ord && !e_unx && last) begin
      exp_head[id] = (exp_head[id] + 1) % 8;
      exp_tot--;
    end
    chk(int'(outstanding) == exp_tot, {req, " outstanding"}, int'(outstanding), exp_tot);
  endtask

  task automatic retire_head(int id, string req);
    respond(id, exp_head[id], 1'b1, 1'b0, 1'b0, req);
  endtask

  task automatic t_reset;
    #1;
    chk(outstanding == 3'd0, "R9 outstanding", int'(outstanding), 0);
    chk(!order_err && !unexp_err, "R9 errors", int'(order_err) + int'(unexp_err), 0);
    chk(req_ready == 1'b1, "R9 ready", int'(req_ready), 1);
    chk(req_seq == 3'd0, "R9 seq", int'(req_seq), 0);
  endtask

  task automatic t_cross_id;
    issue_one(0);
    issue_one(1);
    retire_head(1, "R2 id1 first");
    retire_head(0, "R2 id0 second");
  endtask

  task automatic t_same_id;
    issue_one(2);
    issue_one(2);
    respond(2, (exp_head[2] + 1) % 8, 1'b1, 1'b1, 1'b0, "R5 younger first");
    retire_head(2, "R5 oldest");
    retire_head(2, "R5 next");
  endtask

  task automatic t_unexp;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_ready = 1'b0; rsp_id = 2'd3; rsp_seq = 3'd0; rsp_last = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(unexp_err == 1'b0, "R6 valid without ready ignored", int'(unexp_err), 0);
    respond(3, 0, 1'b1, 1'b0, 1'b1, "R6 nothing pending");
  endtask

  task automatic t_multibeat;
    issue_one(1);
    respond(1, exp_head[1], 1'b0, 1'b0, 1'b0, "R7 beat 0");
    respond(1, exp_head[1], 1'b0, 1'b0, 1'b0, "R7 beat 1");
    retire_head(1, "R7 last beat");
  endtask

  task automatic t_per_id;
    for (int k = 0; k < 4; k++) issue_one(0);
    @(negedge clk);
    req_id = 2'd0; #1;
    chk(req_ready == 1'b0, "R4 id full", int'(req_ready), 0);
    req_id = 2'd1; #1;
    chk(req_ready == 1'b1, "R4 other id open", int'(req_ready), 1);
    for (int k = 0; k < 4; k++) retire_head(0, "R4 drain");
  endtask

  task automatic t_global;
    for (int k = 0; k < 3; k++) issue_one(0);
    for (int k = 0; k < 3; k++) issue_one(1);
    @(negedge clk);
    req_valid = 1'b1; req_id = 2'd2; #1;
    chk(req_ready == 1'b0, "R3 limit blocks", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(outstanding == 3'd6, "R3 held request not taken", int'(outstanding), 6);
    chk(req_seq == 3'(exp_tail[2]), "R3 seq unchanged", int'(req_seq), exp_tail[2]);
    retire_head(0, "R3 one retires");
    #1;
    chk(req_ready == 1'b1, "R3 permit returns", int'(req_ready), 1);
    for (int k = 0; k < 2; k++) retire_head(0, "R3 drain");
    for (int k = 0; k < 3; k++) retire_head(1, "R3 drain");
  endtask

  task automatic t_simul;
    @(negedge clk);
    req_valid = 1'b1; req_id = 2'd3;
    rsp_valid = 1'b1; rsp_ready = 1'b1; rsp_id = 2'd3; rsp_seq = 3'(exp_tail[3]); rsp_last = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0; rsp_ready = 1'b0;
    exp_tail[3] = (exp_tail[3] + 1) % 8; exp_tot++;
    chk(unexp_err == 1'b1, "R6 same-cycle issue not pending", int'(unexp_err), 1);
    chk(int'(outstanding) == exp_tot, "R6 state kept", int'(outstanding), exp_tot);
    issue_one(1);
    @(negedge clk);
    req_valid = 1'b1; req_id = 2'd2;
    rsp_valid = 1'b1; rsp_ready = 1'b1; rsp_id = 2'd3; rsp_seq = 3'(exp_head[3]); rsp_last = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0; rsp_ready = 1'b0;
    exp_tail[2] = (exp_tail[2] + 1) % 8; exp_head[3] = (exp_head[3] + 1) % 8;
    chk(int'(outstanding) == exp_tot, "R8 accept and retire together", int'(outstanding), exp_tot);
    retire_head(1, "R8 drain");
    retire_head(2, "R8 drain");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cross_id();
    t_same_id();
    t_unexp();
    t_multibeat();
    t_per_id();
    t_global();
    t_simul();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule